// File: doc/BRIEF.md
# Display Character and Control Store

This block is the processor-side storage for a four-digit dot-matrix display controller. It keeps one 7-bit character code per digit, two attribute bits per digit (cursor and keep-on), and a 5-bit control word. The control word holds master blank, a 3-bit brightness code and extended-function off. All stored state is driven out in parallel for the font, blanking and dimming logic downstream.

A host writes through a small asynchronous bus: two active-low chip enables, a destination select, a 2-bit digit address, 7 data bits and an active-low write strobe. The strobe is brought into the system clock domain, and a write commits when the synchronized strobe rises. With the destination select high, the data goes to a character slot. With it low, one write updates both attribute bits of the addressed digit and the whole control word. An active-low clear input must stay low for a programmable number of clock cycles. It then restores the power-on contents whatever the chip enables are doing.

Top module: `glyph_store`

## Requirements
- R1: After reset every character slot holds 20h, and all cursor bits, keep-on bits and control fields are 0.
- R2: A write commits only on the rising edge of `wr_n`, seen through a `SYNC_STAGES` synchronizer. Nothing changes while `wr_n` stays low. The bus (`ce_a_n`, `ce_b_n`, `dest_char`, `addr`, `wdata`) must be stable from the falling edge of `wr_n` until `SYNC_STAGES`+2 cycles after its rising edge.
- R3: A write changes no stored state unless `ce_a_n` and `ce_b_n` are both low.
- R4: With `dest_char`=1, `wdata` is stored as the character code of digit `addr` and appears on `char_codes[7*addr +: 7]`. Address 0 is the rightmost digit and address 3 the leftmost.
- R5: With `dest_char`=0, `wdata[0]` becomes `cursor_bits[addr]` and `wdata[1]` becomes `keepon_bits[addr]`. `wdata[2]` loads `master_blank`, `wdata[5:3]` loads `bright_code`, and `wdata[6]` loads `ext_off`. Character codes and the attributes of other digits are unchanged.
- R6: Once `clr_n` has been sampled low on `CLR_HOLD` consecutive clock edges, every character slot is loaded with 20h and every attribute bit and control field with 0. This happens regardless of the chip enables.
- R7: A low pulse on `clr_n` that is sampled on fewer than `CLR_HOLD` consecutive edges changes nothing.
- R8: Writes are accepted in any address order. A later write to a slot replaces the earlier value. Writes stay effective while `master_blank` or `ext_off` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_a_n | input | 1 | Chip enable A, active low |
| ce_b_n | input | 1 | Chip enable B, active low |
| dest_char | input | 1 | 1: character write, 0: attribute and control write |
| addr | input | 2 | Digit address, 0 = rightmost |
| wdata | input | 7 | Write data |
| wr_n | input | 1 | Write strobe, active low, commits on rising edge |
| clr_n | input | 1 | Clear request, active low, qualified by hold time |
| char_codes | output | 28 | Character code of digit i at bits [7i+6:7i] |
| cursor_bits | output | 4 | Cursor bit per digit |
| keepon_bits | output | 4 | Keep-on (blank override) bit per digit |
| master_blank | output | 1 | Master blank field |
| bright_code | output | 3 | Brightness code field |
| ext_off | output | 1 | Extended-function off field |

## Verification
All stored state drives the outputs directly, so a wrong slot, a misrouted bit or a missed clear shows up on the ports `SYNC_STAGES`+2 cycles after the strobe rise or the qualifying clear sample. A write decoded to the wrong digit corrupts a neighbour's code at once and stays visible until that slot is rewritten. A clear counter that fires too early shows up as loss of data after a short clear pulse. A strobe edge detected twice, or on the falling edge, changes the outputs while `wr_n` is still low.

// File: rtl/glyph_store_pkg.sv
package glyph_store_pkg;

  localparam int CHAR_W = 7;
  localparam logic [CHAR_W-1:0] SPACE_CODE = 7'h20;

  // Field order matches wdata[6:2] of an attribute/control write.
  typedef struct packed {
    logic       ext_off;
    logic [2:0] bright;
    logic       master;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/gs_sync.sv
module gs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gs_clear_qual.sv
module gs_clear_qual #(
  parameter int HOLD  = 8,
  parameter int CNT_W = $clog2(HOLD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_s,
  output logic fire
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (!low_s)              cnt_d = '0;
    else if (cnt_q == LIMIT) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign fire = (cnt_q == LIMIT);

  // R7: a single high sample of the clear input cancels any pending clear.
  a_r7_release_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    !low_s |=> !fire);

endmodule

// File: rtl/gs_store.sv
module gs_store
  import glyph_store_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_evt,
  input  logic                     clr_fire,
  input  logic                     ce_a_n,
  input  logic                     ce_b_n,
  input  logic                     dest_char,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [CHAR_W-1:0]        wdata,
  output logic [DIGITS*CHAR_W-1:0] char_codes,
  output logic [DIGITS-1:0]        cursor_bits,
  output logic [DIGITS-1:0]        keepon_bits,
  output ctrl_t                    ctrl
);

  logic  sel;
  logic  char_we;
  logic  attr_we;

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;

  assign sel     = wr_evt && !ce_a_n && !ce_b_n;
  assign char_we = sel &&  dest_char;
  assign attr_we = sel && !dest_char;

  genvar gi;
  generate
    for (gi = 0; gi < DIGITS; gi++) begin : g_digit
      logic              hit;
      logic [CHAR_W-1:0] code_q, code_d;
      logic              cur_q, cur_d;
      logic              keep_q, keep_d;

      assign hit = (addr == ADDR_W'(gi));

      always_comb begin
        code_d = code_q;
        cur_d  = cur_q;
        keep_d = keep_q;
        if (clr_fire) begin
          code_d = SPACE_CODE;
          cur_d  = 1'b0;
          keep_d = 1'b0;
        end else if (hit && char_we) begin
          code_d = wdata;
        end else if (hit && attr_we) begin
          cur_d  = wdata[0];
          keep_d = wdata[1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          code_q <= SPACE_CODE;
          cur_q  <= 1'b0;
          keep_q <= 1'b0;
        end else begin
          code_q <= code_d;
          cur_q  <= cur_d;
          keep_q <= keep_d;
        end
      end

      assign char_codes[gi*CHAR_W +: CHAR_W] = code_q;
      assign cursor_bits[gi]                 = cur_q;
      assign keepon_bits[gi]                 = keep_q;
    end
  endgenerate

  always_comb begin
    ctrl_d = ctrl_q;
    if (clr_fire)     ctrl_d = '0;
    else if (attr_we) ctrl_d = ctrl_t'(wdata[CHAR_W-1:2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;

  // R6: a qualified clear leaves spaces and zeroed attributes/control behind.
  a_r6_clear_restores: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> (char_codes == {DIGITS{SPACE_CODE}}) && (cursor_bits == '0)
                 && (keepon_bits == '0) && (ctrl == '0));

  // R3: a write with either enable high leaves all state untouched.
  a_r3_disabled_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && (ce_a_n || ce_b_n) && !clr_fire) |=>
      $stable(char_codes) && $stable(cursor_bits) && $stable(keepon_bits) && $stable(ctrl));

  // R5: an attribute/control write never disturbs character codes.
  a_r5_attr_keeps_chars: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !ce_a_n && !ce_b_n && !dest_char && !clr_fire) |=> $stable(char_codes));

  // R2: without a strobe event or clear nothing moves.
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_evt && !clr_fire) |=>
      $stable(char_codes) && $stable(cursor_bits) && $stable(keepon_bits) && $stable(ctrl));

endmodule

// File: rtl/glyph_store.sv
module glyph_store
  import glyph_store_pkg::*;
#(
  parameter  int DIGITS      = 4,
  parameter  int SYNC_STAGES = 2,
  parameter  int CLR_HOLD    = 8,
  localparam int ADDR_W      = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce_a_n,
  input  logic                     ce_b_n,
  input  logic                     dest_char,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [CHAR_W-1:0]        wdata,
  input  logic                     wr_n,
  input  logic                     clr_n,
  output logic [DIGITS*CHAR_W-1:0] char_codes,
  output logic [DIGITS-1:0]        cursor_bits,
  output logic [DIGITS-1:0]        keepon_bits,
  output logic                     master_blank,
  output logic [2:0]               bright_code,
  output logic                     ext_off
);

  logic  rst_sync_n;
  logic  wr_s;
  logic  wr_prev_q;
  logic  wr_evt;
  logic  clr_s;
  logic  clr_fire;
  ctrl_t ctrl;

  gs_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  gs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wr_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(wr_n), .q(wr_s)
  );

  gs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_clr_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(clr_n), .q(clr_s)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) wr_prev_q <= 1'b1;
    else             wr_prev_q <= wr_s;
  end

  assign wr_evt = wr_s && !wr_prev_q;

  gs_clear_qual #(.HOLD(CLR_HOLD)) u_clr_qual (
    .clk(clk), .rst_n(rst_sync_n), .low_s(!clr_s), .fire(clr_fire)
  );

  gs_store #(.DIGITS(DIGITS), .ADDR_W(ADDR_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_evt      (wr_evt),
    .clr_fire    (clr_fire),
    .ce_a_n      (ce_a_n),
    .ce_b_n      (ce_b_n),
    .dest_char   (dest_char),
    .addr        (addr),
    .wdata       (wdata),
    .char_codes  (char_codes),
    .cursor_bits (cursor_bits),
    .keepon_bits (keepon_bits),
    .ctrl        (ctrl)
  );

  assign master_blank = ctrl.master;
  assign bright_code  = ctrl.bright;
  assign ext_off      = ctrl.ext_off;

  // R2: one strobe rise yields exactly one single-cycle write event.
  a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_evt |=> !wr_evt);

endmodule

// File: tb/glyph_store_test.sv
module glyph_store_test;

  localparam int DIGITS   = 4;
  localparam int SYNC     = 2;
  localparam int HOLD     = 8;
  localparam int CW       = 7;

  logic clk = 1'b0;
  logic rst_n, ce_a_n, ce_b_n, dest_char, wr_n, clr_n;
  logic [1:0] addr;
  logic [CW-1:0] wdata;
  logic [DIGITS*CW-1:0] char_codes;
  logic [DIGITS-1:0] cursor_bits, keepon_bits;
  logic master_blank, ext_off;
  logic [2:0] bright_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [CW-1:0] e_chr [DIGITS];
  logic [DIGITS-1:0] e_cur, e_keep;
  logic [4:0] e_ctrl;   // {ext_off, bright[2:0], master}

  always #4 clk = ~clk;

  glyph_store #(.DIGITS(DIGITS), .SYNC_STAGES(SYNC), .CLR_HOLD(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .ce_a_n(ce_a_n), .ce_b_n(ce_b_n),
    .dest_char(dest_char), .addr(addr), .wdata(wdata), .wr_n(wr_n), .clr_n(clr_n),
    .char_codes(char_codes), .cursor_bits(cursor_bits), .keepon_bits(keepon_bits),
    .master_blank(master_blank), .bright_code(bright_code), .ext_off(ext_off)
  );

  task automatic model_clear();
    for (int i = 0; i < DIGITS; i++) e_chr[i] = 7'h20;
    e_cur = '0; e_keep = '0; e_ctrl = '0;
  endtask

  task automatic check_all(input string req);
    logic [DIGITS*CW-1:0] exp_c;
    for (int i = 0; i < DIGITS; i++) exp_c[i*CW +: CW] = e_chr[i];
    n_chk++;
    if (char_codes !== exp_c || cursor_bits !== e_cur || keepon_bits !== e_keep ||
        {ext_off, bright_code, master_blank} !== e_ctrl) begin
      n_fail++;
      $display("FAIL %s: chars=%h cur=%b keep=%b ctrl=%b expected chars=%h cur=%b keep=%b ctrl=%b",
               req, char_codes, cursor_bits, keepon_bits, {ext_off, bright_code, master_blank},
               exp_c, e_cur, e_keep, e_ctrl);
    end
  endtask

  task automatic model_write(input logic ea, input logic eb, input logic dc,
                             input logic [1:0] a, input logic [CW-1:0] d);
    if (!ea && !eb) begin
      if (dc) e_chr[a] = d;
      else begin
        e_cur[a] = d[0]; e_keep[a] = d[1]; e_ctrl = d[6:2];
      end
    end
  endtask

  task automatic bus_write(input logic ea, input logic eb, input logic dc,
                           input logic [1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    ce_a_n = ea; ce_b_n = eb; dest_char = dc; addr = a; wdata = d;
    @(negedge clk); wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (SYNC + 3) @(negedge clk);
    ce_a_n = 1'b1; ce_b_n = 1'b1;
    @(negedge clk);
    model_write(ea, eb, dc, a, d);
  endtask

  task automatic clear_pulse(input int len);
    @(negedge clk); clr_n = 1'b0;
    repeat (len) @(negedge clk);
    clr_n = 1'b1;
    repeat (SYNC + 4) @(negedge clk);
    if (len >= HOLD) model_clear();
  endtask

  task automatic t_reset();
    model_clear();
    check_all("R1 reset state");
  endtask

  task automatic t_char_order();
    bus_write(0, 0, 1, 2'd0, 7'h41);
    bus_write(0, 0, 1, 2'd1, 7'h42);
    bus_write(0, 0, 1, 2'd2, 7'h43);
    bus_write(0, 0, 1, 2'd3, 7'h44);
    check_all("R4 char slots by address, 0 rightmost");
  endtask

  task automatic t_strobe_edge();
    @(negedge clk);
    ce_a_n = 0; ce_b_n = 0; dest_char = 1; addr = 2'd2; wdata = 7'h5a;
    @(negedge clk); wr_n = 1'b0;
    repeat (SYNC + 6) @(negedge clk);
    check_all("R2 no change while strobe low");
    wr_n = 1'b1;
    repeat (SYNC + 3) @(negedge clk);
    ce_a_n = 1; ce_b_n = 1;
    model_write(0, 0, 1, 2'd2, 7'h5a);
    check_all("R2 commit on strobe rise");
  endtask

  task automatic t_attr_ctrl();
    bus_write(0, 0, 0, 2'd1, 7'b1_101_1_11);
    check_all("R5 attr and control fields digit1");
    bus_write(0, 0, 0, 2'd3, 7'b0_010_0_01);
    check_all("R5 second attr write keeps digit1 attrs");
  endtask

  task automatic t_enables();
    bus_write(1, 0, 1, 2'd0, 7'h7f);
    check_all("R3 ce_a_n high blocks char write");
    bus_write(0, 1, 0, 2'd0, 7'h7f);
    check_all("R3 ce_b_n high blocks ctrl write");
    bus_write(1, 1, 1, 2'd3, 7'h00);
    check_all("R3 both enables high");
  endtask

  task automatic t_any_order_blanked();
    bus_write(0, 0, 0, 2'd0, 7'b1_000_1_00);
    check_all("R8 master blank and ext_off set");
    bus_write(0, 0, 1, 2'd3, 7'h61);
    bus_write(0, 0, 1, 2'd0, 7'h30);
    bus_write(0, 0, 1, 2'd3, 7'h62);
    check_all("R8 writes in any order while blanked");
  endtask

  task automatic t_clear();
    clear_pulse(HOLD - 1);
    check_all("R7 short clear ignored");
    clear_pulse(2);
    check_all("R7 very short clear ignored");
    @(negedge clk); ce_a_n = 1; ce_b_n = 0;
    clear_pulse(HOLD + 2);
    ce_a_n = 1; ce_b_n = 1;
    check_all("R6 clear with enables inactive");
    bus_write(0, 0, 0, 2'd2, 7'h7f);
    bus_write(0, 0, 1, 2'd1, 7'h23);
    clear_pulse(HOLD);
    check_all("R6 clear at exact hold");
  endtask

  initial begin
    rst_n = 0; ce_a_n = 1; ce_b_n = 1; dest_char = 1; addr = '0; wdata = '0;
    wr_n = 1; clr_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_char_order();
    t_strobe_edge();
    t_attr_ctrl();
    t_enables();
    t_any_order_blanked();
    t_clear();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule